// File: doc/BRIEF.md
# Read Strobe Delay Calibrator

This block trains the read-capture timing of a double-data-rate memory port. After a start request it resets the strobe delay line to tap zero. It records the strobe level seen there as a reference. It then walks the delay one tap at a time. At every tap it lets the line settle and takes several samples of the delayed strobe with the core clock. The first tap where the level has solidly moved away from the reference marks one strobe transition, and the next such tap marks the transition after it. The distance between the two is half a strobe period. From it the block places the data-line delay a quarter period past the first transition, which is 90 degrees into the bit.

The delay line is short: it has a hard top tap. When the strobe period is long, only one transition may fit inside the range. The block then reports a single-edge result and parks the data delay a fixed number of taps away from that transition instead of failing. If no transition is found at all, it raises a fail flag and zeroes both delays. A manual mode bypasses all of this and drives delays supplied from outside.

Top module: `strobe_delay_cal`

## Requirements
- R1: After reset, strobeTap and dataTap are 0, and calDone, calFail, singleEdge, tapInc and tapRst are all low.
- R2: A startReq while manualMode is low pulses tapRst for one cycle and sets strobeTap to 0. The search then raises tapInc once per probed tap. Consecutive tapInc pulses are exactly SETTLE_CYC + HOLD_CNT cycles apart, and strobeTap rises by one after each pulse.
- R3: The strobe level at tap 0 is the reference. An edge is the first later tap at which all HOLD_CNT samples differ from the reference. After the first edge the reference flips, so the second edge is the next tap whose samples all differ from the new reference.
- R4: A tap at which the sampled strobe does not hold the changed level for all HOLD_CNT samples (for example, toggling every cycle) is not taken as an edge.
- R5: When two edges at taps E1 < E2 are found, dataTap = min(E1 + floor((E2 - E1) / 2), MAX_TAP). strobeTap is left at E2, singleEdge is low, and calDone pulses.
- R6: When only one edge E1 is found by MAX_TAP, singleEdge goes high and calDone pulses. dataTap = E1 - SINGLE_SHIFT if E1 >= SINGLE_SHIFT, otherwise min(E1 + SINGLE_SHIFT, MAX_TAP). strobeTap is left at MAX_TAP.
- R7: When no edge is found up to MAX_TAP, calFail goes high, strobeTap and dataTap return to 0, and calDone does not pulse.
- R8: calDone is high for exactly one cycle per successful calibration. dataTap, strobeTap, calFail and singleEdge then stay unchanged until the next start request.
- R9: While manualMode is high, strobeTap and dataTap equal manualStrobeTap and manualDataTap, and startReq is ignored (no tapRst, tapInc or calDone). When manualMode drops, the previously calibrated values reappear.
- R10: The search never steps strobeTap past MAX_TAP = 2^TAP_W - 1. The number of tapInc pulses in one search equals the final search tap (E2, or MAX_TAP in the single-edge and fail cases).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that also samples the delayed strobe |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a calibration (ignored while busy or in manual mode) |
| manualMode | input | 1 | Bypass calibration and drive the manual tap values |
| manualStrobeTap | input | TAP_W | Strobe delay used in manual mode |
| manualDataTap | input | TAP_W | Data delay used in manual mode |
| strobeSample | input | 1 | Delayed strobe level sampled by the core clock |
| tapInc | output | 1 | One-cycle request to add one tap to the strobe delay |
| tapRst | output | 1 | One-cycle request to return the strobe delay to tap 0 |
| strobeTap | output | TAP_W | Current strobe delay tap |
| dataTap | output | TAP_W | Data-line delay tap |
| calDone | output | 1 | One-cycle pulse on successful calibration |
| calFail | output | 1 | Held high after a calibration that found no edge |
| singleEdge | output | 1 | Held high when the result came from the single-edge fallback |

## Verification
A wrong reference level or a wrong hold count moves the reported edge taps. That shows up as a wrong dataTap or strobeTap at the very cycle calDone pulses, and as a wrong number of tapInc pulses during the run. A bad settle counter changes the spacing of tapInc pulses on the first probed tap, well before the result appears. The sweep covers strobe half-periods from one tap to longer than the delay line, at several phases. It therefore reaches the two-edge, single-edge and fail outcomes. It also covers single-edge edge taps on both sides of the shift distance and the saturation at the top tap.

// File: rtl/strobe_cal_pkg.sv
package strobe_cal_pkg;

  // Command strobes from the sequencer to the tap datapath
  typedef struct packed {
    logic clrTaps;     // zero strobe, data and first-edge taps
    logic setRef;      // capture reference level at tap 0
    logic incTap;      // advance strobe delay by one tap
    logic latchFirst;  // record first edge tap and flip reference
    logic loadTwo;     // compute data tap from two edges
    logic loadSingle;  // compute data tap from single-edge fallback
  } calCtl_t;

endpackage

// File: rtl/strobe_cal_path.sv
module strobe_cal_path
  import strobe_cal_pkg::*;
#(
  parameter int TAP_W        = 6,
  parameter int SINGLE_SHIFT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  calCtl_t          ctl,
  input  logic             strobeSample,
  output logic             levelDiff,
  output logic             atMax,
  output logic [TAP_W-1:0] strobeTapQ,
  output logic [TAP_W-1:0] dataTapQ
);

  localparam int MAX_TAP = (1 << TAP_W) - 1;
  localparam int SUM_W   = TAP_W + 1;
  localparam logic [SUM_W-1:0] MAX_WIDE   = SUM_W'(MAX_TAP);
  localparam logic [SUM_W-1:0] SHIFT_WIDE = SUM_W'(SINGLE_SHIFT);

  logic [TAP_W-1:0] firstTapQ;
  logic             refLvlQ;

  logic [TAP_W-1:0] edgeSrc;
  logic [SUM_W-1:0] halfSpan;
  logic [SUM_W-1:0] twoSum;
  logic [TAP_W-1:0] twoTap;
  logic [SUM_W-1:0] upSum;
  logic [TAP_W-1:0] singleTap;

  assign levelDiff = strobeSample ^ refLvlQ;
  assign atMax     = (strobeTapQ == TAP_W'(MAX_TAP));

  // Two-edge placement: first edge plus a quarter period (half the edge spacing)
  always_comb begin
    halfSpan = SUM_W'(strobeTapQ - firstTapQ) >> 1;
    twoSum   = SUM_W'(firstTapQ) + halfSpan;
    twoTap   = (twoSum > MAX_WIDE) ? TAP_W'(MAX_TAP) : twoSum[TAP_W-1:0];
  end

  // Single-edge fallback: step a fixed distance away from the only edge
  always_comb begin
    edgeSrc = ctl.latchFirst ? strobeTapQ : firstTapQ;
    upSum   = SUM_W'(edgeSrc) + SHIFT_WIDE;
    if (SUM_W'(edgeSrc) >= SHIFT_WIDE)
      singleTap = TAP_W'(SUM_W'(edgeSrc) - SHIFT_WIDE);
    else if (upSum > MAX_WIDE)
      singleTap = TAP_W'(MAX_TAP);
    else
      singleTap = upSum[TAP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeTapQ <= '0;
      dataTapQ   <= '0;
      firstTapQ  <= '0;
      refLvlQ    <= 1'b0;
    end else begin
      if (ctl.clrTaps) begin
        strobeTapQ <= '0;
        dataTapQ   <= '0;
        firstTapQ  <= '0;
      end else if (ctl.incTap) begin
        strobeTapQ <= strobeTapQ + 1'b1;
      end
      if (ctl.setRef)
        refLvlQ <= strobeSample;
      else if (ctl.latchFirst)
        refLvlQ <= ~refLvlQ;
      if (ctl.latchFirst)
        firstTapQ <= strobeTapQ;
      if (ctl.loadTwo)
        dataTapQ <= twoTap;
      else if (ctl.loadSingle)
        dataTapQ <= singleTap;
    end
  end

  // R2: one tap per increment request
  p_inc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incTap && !ctl.clrTaps) |=> strobeTapQ == $past(strobeTapQ) + 1'b1);

  // R10: never asked to step beyond the top tap
  p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.incTap |-> !atMax);

  // R8: data tap only moves on an explicit load or clear
  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.clrTaps || ctl.loadTwo || ctl.loadSingle) |=> $stable(dataTapQ));

endmodule

// File: rtl/strobe_cal_ctrl.sv
module strobe_cal_ctrl
  import strobe_cal_pkg::*;
#(
  parameter int SETTLE_CYC = 2,
  parameter int HOLD_CNT   = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    manualMode,
  input  logic    levelDiff,
  input  logic    atMax,
  output calCtl_t ctl,
  output logic    calDone,
  output logic    calFail,
  output logic    singleEdge
);

  localparam int SET_W  = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam int HOLD_W = (HOLD_CNT < 2) ? 1 : $clog2(HOLD_CNT + 1);
  localparam logic [SET_W-1:0]  SET_LAST  = SET_W'(SETTLE_CYC - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CNT - 1);

  typedef enum logic [1:0] {C_IDLE, C_SETTLE, C_REF, C_SAMPLE} calState_t;

  calState_t        stateQ, stateD;
  logic [SET_W-1:0] settleCntQ;
  logic [HOLD_W-1:0] holdCntQ;
  logic             missQ;
  logic             refPendQ;
  logic             haveFirstQ;
  logic             lastSample;
  logic             qualified;

  assign lastSample = (stateQ == C_SAMPLE) && (holdCntQ == HOLD_LAST);
  assign qualified  = !missQ && levelDiff;

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    unique case (stateQ)
      C_IDLE: begin
        if (startReq && !manualMode) begin
          ctl.clrTaps = 1'b1;
          stateD      = C_SETTLE;
        end
      end
      C_SETTLE: begin
        if (settleCntQ == SET_LAST)
          stateD = refPendQ ? C_REF : C_SAMPLE;
      end
      C_REF: begin
        ctl.setRef = 1'b1;
        ctl.incTap = 1'b1;
        stateD     = C_SETTLE;
      end
      C_SAMPLE: begin
        if (lastSample) begin
          if (qualified && haveFirstQ) begin
            ctl.loadTwo = 1'b1;
            stateD      = C_IDLE;
          end else if (qualified) begin
            ctl.latchFirst = 1'b1;
            if (atMax) begin
              ctl.loadSingle = 1'b1;
              stateD         = C_IDLE;
            end else begin
              ctl.incTap = 1'b1;
              stateD     = C_SETTLE;
            end
          end else if (atMax) begin
            if (haveFirstQ) ctl.loadSingle = 1'b1;
            else            ctl.clrTaps    = 1'b1;
            stateD = C_IDLE;
          end else begin
            ctl.incTap = 1'b1;
            stateD     = C_SETTLE;
          end
        end
      end
      default: stateD = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= C_IDLE;
      settleCntQ <= '0;
      holdCntQ   <= '0;
      missQ      <= 1'b0;
      refPendQ   <= 1'b0;
      haveFirstQ <= 1'b0;
      calDone    <= 1'b0;
      calFail    <= 1'b0;
      singleEdge <= 1'b0;
    end else begin
      stateQ  <= stateD;
      calDone <= 1'b0;
      if (stateQ == C_SETTLE) settleCntQ <= settleCntQ + 1'b1;
      else                    settleCntQ <= '0;
      if (stateQ == C_SAMPLE) begin
        holdCntQ <= holdCntQ + 1'b1;
        missQ    <= missQ | !levelDiff;
      end else begin
        holdCntQ <= '0;
        missQ    <= 1'b0;
      end
      if (stateQ == C_IDLE && ctl.clrTaps) begin
        refPendQ   <= 1'b1;
        haveFirstQ <= 1'b0;
        calFail    <= 1'b0;
        singleEdge <= 1'b0;
      end
      if (ctl.setRef) refPendQ <= 1'b0;
      if (ctl.latchFirst) haveFirstQ <= 1'b1;
      if (ctl.loadTwo) calDone <= 1'b1;
      if (ctl.loadSingle) begin
        calDone    <= 1'b1;
        singleEdge <= 1'b1;
      end
      if (stateQ == C_SAMPLE && ctl.clrTaps) calFail <= 1'b1;
    end
  end

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    calDone |=> !calDone);

  // R7: a failed search never reports completion
  p_done_fail_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(calDone && calFail));

  // R9: manual mode blocks a new search
  p_manual_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == C_IDLE && manualMode) |=> stateQ == C_IDLE);

endmodule

// File: rtl/strobe_delay_cal.sv
module strobe_delay_cal
  import strobe_cal_pkg::*;
#(
  parameter int TAP_W        = 6,
  parameter int SETTLE_CYC   = 2,
  parameter int HOLD_CNT     = 4,
  parameter int SINGLE_SHIFT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             manualMode,
  input  logic [TAP_W-1:0] manualStrobeTap,
  input  logic [TAP_W-1:0] manualDataTap,
  input  logic             strobeSample,
  output logic             tapInc,
  output logic             tapRst,
  output logic [TAP_W-1:0] strobeTap,
  output logic [TAP_W-1:0] dataTap,
  output logic             calDone,
  output logic             calFail,
  output logic             singleEdge
);

  calCtl_t          ctl;
  logic             levelDiff;
  logic             atMax;
  logic [TAP_W-1:0] calStrobeTap;
  logic [TAP_W-1:0] calDataTap;

  strobe_cal_ctrl #(
    .SETTLE_CYC (SETTLE_CYC),
    .HOLD_CNT   (HOLD_CNT)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .manualMode (manualMode),
    .levelDiff  (levelDiff),
    .atMax      (atMax),
    .ctl        (ctl),
    .calDone    (calDone),
    .calFail    (calFail),
    .singleEdge (singleEdge)
  );

  strobe_cal_path #(
    .TAP_W        (TAP_W),
    .SINGLE_SHIFT (SINGLE_SHIFT)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .strobeSample (strobeSample),
    .levelDiff    (levelDiff),
    .atMax        (atMax),
    .strobeTapQ   (calStrobeTap),
    .dataTapQ     (calDataTap)
  );

  assign tapInc    = ctl.incTap;
  assign tapRst    = ctl.clrTaps;
  assign strobeTap = manualMode ? manualStrobeTap : calStrobeTap;
  assign dataTap   = manualMode ? manualDataTap   : calDataTap;

  // R7: a failed calibration leaves both delays at zero
  p_fail_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (calFail && !manualMode) |-> (strobeTap == '0 && dataTap == '0));

endmodule

// File: tb/tb_strobe_delay_cal.sv
module tb_strobe_delay_cal;

  localparam int TAP_W   = 6;
  localparam int SETTLE  = 2;
  localparam int HOLD    = 4;
  localparam int SHIFT   = 16;
  localparam int MAXT    = (1 << TAP_W) - 1;
  localparam int GAP     = SETTLE + HOLD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic manualMode = 1'b0;
  logic [TAP_W-1:0] manualStrobeTap = '0;
  logic [TAP_W-1:0] manualDataTap = '0;
  logic strobeSample;
  logic tapInc, tapRst, calDone, calFail, singleEdge;
  logic [TAP_W-1:0] strobeTap, dataTap;

  int halfPer = 8;
  int phase = 0;
  int noisyTap = 0;
  logic tgl = 1'b0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int incCnt = 0, rstCnt = 0, doneCnt = 0, gapBad = 0, gap = 0;

  always #4 clk = ~clk;

  strobe_delay_cal #(
    .TAP_W(TAP_W), .SETTLE_CYC(SETTLE), .HOLD_CNT(HOLD), .SINGLE_SHIFT(SHIFT)
  ) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .manualMode(manualMode),
    .manualStrobeTap(manualStrobeTap), .manualDataTap(manualDataTap),
    .strobeSample(strobeSample), .tapInc(tapInc), .tapRst(tapRst),
    .strobeTap(strobeTap), .dataTap(dataTap), .calDone(calDone),
    .calFail(calFail), .singleEdge(singleEdge)
  );

  function automatic logic lvl(input int t);
    return logic'(((t + phase) / halfPer) % 2);
  endfunction

  // delay-line model: noisy tap toggles every cycle
  always_ff @(posedge clk) tgl <= ~tgl;
  assign strobeSample = (noisyTap != 0 && int'(strobeTap) == noisyTap) ? tgl : lvl(int'(strobeTap));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
      finishRun();
    end
    gap++;
    if (tapInc) begin
      if (incCnt > 0 && gap != GAP) gapBad++;
      incCnt++;
      gap = 0;
    end
    if (tapRst) rstCnt++;
    if (calDone) doneCnt++;
  end

  task automatic runCal(input int hp, input int ph, input int nz);
    int ref0, e1, e2, expData, expStrobe, expSingle, expFail, expIncs, w;
    logic r;
    halfPer = hp; phase = ph; noisyTap = nz;
    // expected edges from the delay-line model (R3, R4)
    r = lvl(0); e1 = -1; e2 = -1; ref0 = 0;
    for (int t = 1; t <= MAXT; t++) begin
      if (!(nz != 0 && t == nz) && lvl(t) != r) begin
        if (e1 < 0) begin e1 = t; r = ~r; end
        else begin e2 = t; break; end
      end
    end
    if (e2 > 0) begin
      expData = e1 + (e2 - e1) / 2; if (expData > MAXT) expData = MAXT;
      expStrobe = e2; expSingle = 0; expFail = 0; expIncs = e2;
    end else if (e1 > 0) begin
      if (e1 >= SHIFT) expData = e1 - SHIFT;
      else begin expData = e1 + SHIFT; if (expData > MAXT) expData = MAXT; end
      expStrobe = MAXT; expSingle = 1; expFail = 0; expIncs = MAXT;
    end else begin
      expData = 0; expStrobe = 0; expSingle = 0; expFail = 1; expIncs = MAXT;
    end
    @(negedge clk);
    incCnt = 0; rstCnt = 0; doneCnt = 0; gapBad = 0; gap = 0;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    w = 0;
    while (!calDone && !calFail && w < 3000) begin @(negedge clk); w++; end
    chk("R2 tapRst pulses", rstCnt, expFail ? 2 : 1);
    chk("R2 tapInc spacing", gapBad, 0);
    chk("R10 tapInc count", incCnt, expIncs);
    chk("R5/R6 dataTap", int'(dataTap), expData);
    chk("R5/R6 strobeTap", int'(strobeTap), expStrobe);
    chk("R6 singleEdge", int'(singleEdge), expSingle);
    chk("R7 calFail", int'(calFail), expFail);
    repeat (5) @(negedge clk);
    chk("R8 done pulse count", doneCnt, expFail ? 0 : 1);
    chk("R8 dataTap stable", int'(dataTap), expData);
    chk("R8 strobeTap stable", int'(strobeTap), expStrobe);
    chk("R8 flags stable", int'({calFail, singleEdge}), expFail * 2 + expSingle);
  endtask

  initial begin
    int keepS, keepD;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 strobeTap", int'(strobeTap), 0);
    chk("R1 dataTap", int'(dataTap), 0);
    chk("R1 flags", int'({calDone, calFail, singleEdge, tapInc, tapRst}), 0);
    rstN = 1'b1;
    // R3 R5 R6 R7 R10: sweep half-periods across and beyond the tap range
    for (int hp = 1; hp <= 70; hp++) begin
      runCal(hp, 0, 0);
      if (hp > 2) runCal(hp, (hp - 1) / 2, 0);
      if (hp > 1) runCal(hp, hp - 1, 0);
    end
    // R4: jittery tap at the true first edge is skipped
    for (int hp = 3; hp <= 20; hp++) runCal(hp, 0, hp);
    // R4: jittery tap at the second edge in a two-edge case
    runCal(10, 3, 17);
    // R9: manual override
    runCal(12, 0, 0);
    keepS = int'(strobeTap); keepD = int'(dataTap);
    @(negedge clk);
    manualMode = 1'b1; manualStrobeTap = 6'd17; manualDataTap = 6'd42;
    incCnt = 0; rstCnt = 0; doneCnt = 0;
    @(negedge clk);
    chk("R9 manual strobeTap", int'(strobeTap), 17);
    chk("R9 manual dataTap", int'(dataTap), 42);
    startReq = 1'b1; @(negedge clk); startReq = 1'b0;
    repeat (60) @(negedge clk);
    chk("R9 start ignored", incCnt + rstCnt + doneCnt, 0);
    manualMode = 1'b0;
    @(negedge clk);
    chk("R9 restored strobeTap", int'(strobeTap), keepS);
    chk("R9 restored dataTap", int'(dataTap), keepD);
    finishRun();
  end

endmodule